// File: doc/BRIEF.md
# Angle Output Latch and Bus Interface

This block sits between the angle counter of a tracking converter and a shared microprocessor bus. A 14-bit angle arrives from the counter every clock. Each one-LSB change of the counter is framed by a converter-busy pulse. While the inhibit input is high, a holding register follows the counter. During the first half of a busy pulse the counter may still be settling, so the register does not take the counter value in that window. Driving inhibit low freezes the register so that software can read a consistent angle. The converter keeps tracking while the register is frozen.

If inhibit goes low while a busy pulse is in progress, the freeze is deferred. The register keeps sampling from the middle of the pulse onward, takes the settled value on the first cycle after the pulse ends, and only then freezes. The held angle is read through two active-low byte enables. The enable for the upper byte gives angle bits 13..6. The enable for the lower byte gives bits 5..0, zero-extended to eight bits. With both enables low, the whole angle appears on a 16-bit lane. Tri-state drive is modelled as data plus an output-enable per lane. A disabled lane carries zero.

Control is a three-state machine. TRACK is transparent. DEFER holds an inhibit request that is waiting for busy to end. HOLD is frozen. The transitions are as follows:
- TRACK goes to DEFER when inhibit is low while busy is high.
- TRACK goes to HOLD when inhibit is low while busy is low.
- DEFER goes to HOLD on the first cycle in which busy is low; this is the capture cycle.
- DEFER goes back to TRACK when inhibit is released.
- HOLD goes to TRACK when inhibit is released.

Top module: `angle_latch_bus`

## Requirements
- R1: While rst_n is low, both output enables are 0 and both lanes read 0. After reset the state is TRACK with no pending inhibit, and the held angle is 0.
- R2: In TRACK, with inhibit_n high and busy low, the held angle equals the angle_in value present at the previous rising clock edge.
- R3: During a busy pulse, angle_in is ignored at the first BUSY_CYC/2 rising edges after busy goes high. It is sampled from the next edge onward.
- R4: When inhibit_n is sampled low while busy is low, the held angle is frozen at once. The angle_in value present at that same edge is not taken, and later angle_in changes have no effect.
- R5: When inhibit_n is sampled low while busy is high, sampling continues as in R3 until busy falls. The angle_in value at the first edge with busy low is then captured, and the held angle is frozen after that.
- R6: A deferred inhibit is cancelled if inhibit_n returns high before busy ends. When inhibit_n returns high from HOLD, the first edge does not load and the second edge loads angle_in.
- R7: With en_hi_n low and en_lo_n high, byte_oe is 1, byte_q is held angle bits 13..6, and word_oe is 0.
- R8: With en_lo_n low and en_hi_n high, byte_oe is 1, byte_q is {2'b00, held angle bits 5..0}, and word_oe is 0.
- R9: With both enables low, word_oe is 1, word_q is {2'b00, held angle}, byte_oe is 0, and byte_q is 0.
- R10: With both enables high, both output enables are 0 and both lanes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| angle_in | input | 14 | Angle from the converter counter |
| busy | input | 1 | Converter-busy pulse, high for about BUSY_CYC cycles per update |
| inhibit_n | input | 1 | Freeze request, active low |
| en_hi_n | input | 1 | Upper-byte enable, active low |
| en_lo_n | input | 1 | Lower-byte enable, active low |
| byte_q | output | 8 | Byte lane data, zero when not driven |
| byte_oe | output | 1 | Byte lane drive enable |
| word_q | output | 16 | 16-bit lane data, zero when not driven |
| word_oe | output | 1 | 16-bit lane drive enable |

## Verification
A wrong control state shows up at the next rising edge as a held angle that moves when it should be frozen, or that stays put when it should track. This is seen on word_q within one or two cycles after angle_in changes. A busy-phase counter that is off by one shows as a mid-pulse angle value appearing on the lanes. This is checked by changing angle_in both just before and just after the midpoint. Enable decoding errors are combinational and appear on the lanes in the same cycle that the enables change.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_DEFER = 2'd1,
        ST_HOLD  = 2'd2
    } latch_state_t;
endpackage

// File: rtl/busy_phase.sv
module busy_phase #(
    parameter int BUSY_CYC = 47
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic mid_ok
);
    localparam int MID = BUSY_CYC / 2;
    localparam int CW  = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(BUSY_CYC);
    localparam logic [CW-1:0] CMID = CW'(MID);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!busy)
            cnt_q <= '0;
        else if (cnt_q != CMAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign mid_ok = (cnt_q >= CMID);
endmodule

// File: rtl/inhibit_fsm.sv
module inhibit_fsm
    import angle_latch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         mid_ok,
    input  logic         inhibit_n,
    output logic         load,
    output latch_state_t st
);
    latch_state_t st_nx;
    logic         sample_ok;

    assign sample_ok = !busy || mid_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_TRACK;
        else
            st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        load  = 1'b0;
        unique case (st)
            ST_TRACK: begin
                if (inhibit_n) begin
                    load = sample_ok;
                end else if (busy) begin
                    load  = mid_ok;
                    st_nx = ST_DEFER;
                end else begin
                    st_nx = ST_HOLD;
                end
            end
            ST_DEFER: begin
                if (inhibit_n) begin
                    load  = sample_ok;
                    st_nx = ST_TRACK;
                end else if (!busy) begin
                    load  = 1'b1;
                    st_nx = ST_HOLD;
                end else begin
                    load = mid_ok;
                end
            end
            ST_HOLD: begin
                if (inhibit_n)
                    st_nx = ST_TRACK;
            end
            default: st_nx = ST_TRACK;
        endcase
    end
endmodule

// File: rtl/angle_hold.sv
module angle_hold #(
    parameter int ANG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ANG_W-1:0] angle_in,
    output logic [ANG_W-1:0] hold_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (load)
            hold_q <= angle_in;
    end
endmodule

// File: rtl/bus_lanes.sv
module bus_lanes #(
    parameter int ANG_W  = 14,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              rst_n,
    input  logic [ANG_W-1:0]  hold_q,
    input  logic              en_hi_n,
    input  logic              en_lo_n,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_oe,
    output logic [WORD_W-1:0] word_q,
    output logic              word_oe
);
    localparam int LO_W = ANG_W - BYTE_W;

    logic hi_sel, lo_sel;
    logic [BYTE_W-1:0] hi_byte, lo_byte;

    assign hi_sel  = rst_n && !en_hi_n && en_lo_n;
    assign lo_sel  = rst_n && !en_lo_n && en_hi_n;
    assign hi_byte = hold_q[ANG_W-1:LO_W];
    assign lo_byte = {{(BYTE_W-LO_W){1'b0}}, hold_q[LO_W-1:0]};

    always_comb begin
        byte_oe = hi_sel || lo_sel;
        word_oe = rst_n && !en_hi_n && !en_lo_n;
        byte_q  = '0;
        word_q  = '0;
        if (hi_sel)
            byte_q = hi_byte;
        else if (lo_sel)
            byte_q = lo_byte;
        if (word_oe)
            word_q = {{(WORD_W-ANG_W){1'b0}}, hold_q};
    end
endmodule

// File: rtl/angle_latch_bus.sv
module angle_latch_bus
    import angle_latch_pkg::*;
#(
    parameter int ANG_W    = 14,
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 16,
    parameter int BUSY_CYC = 47,
    parameter int GAP_CYC  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ANG_W-1:0]  angle_in,
    input  logic              busy,
    input  logic              inhibit_n,
    input  logic              en_hi_n,
    input  logic              en_lo_n,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_oe,
    output logic [WORD_W-1:0] word_q,
    output logic              word_oe
);
    logic             mid_ok;
    logic             load;
    latch_state_t     st;
    logic [ANG_W-1:0] hold_q;

    busy_phase #(.BUSY_CYC(BUSY_CYC)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .mid_ok (mid_ok)
    );

    inhibit_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .mid_ok    (mid_ok),
        .inhibit_n (inhibit_n),
        .load      (load),
        .st        (st)
    );

    angle_hold #(.ANG_W(ANG_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .angle_in (angle_in),
        .hold_q   (hold_q)
    );

    bus_lanes #(.ANG_W(ANG_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_lanes (
        .rst_n   (rst_n),
        .hold_q  (hold_q),
        .en_hi_n (en_hi_n),
        .en_lo_n (en_lo_n),
        .byte_q  (byte_q),
        .byte_oe (byte_oe),
        .word_q  (word_q),
        .word_oe (word_oe)
    );
endmodule

// File: rtl/angle_latch_bus_chk.sv
module angle_latch_bus_chk
    import angle_latch_pkg::*;
#(
    parameter int ANG_W   = 14,
    parameter int WORD_W  = 16,
    parameter int GAP_CYC = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              inhibit_n,
    input logic              en_hi_n,
    input logic              en_lo_n,
    input logic              mid_ok,
    input latch_state_t      st,
    input logic [ANG_W-1:0]  hold_q,
    input logic              byte_oe,
    input logic              word_oe,
    input logic [WORD_W-1:0] word_q
);
    localparam int GW = $clog2(GAP_CYC + 1) + 1;
    localparam logic [GW-1:0] GMAX = GW'(GAP_CYC);

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_cnt <= GMAX;
        else if (busy)
            gap_cnt <= '0;
        else if (gap_cnt != GMAX)
            gap_cnt <= gap_cnt + 1'b1;
    end

    // input rule: minimum idle gap between busy pulses
    busy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (gap_cnt >= GMAX));

    // R3
    early_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mid_ok) |=> $stable(hold_q));

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> $stable(hold_q));

    // R5
    defer_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRACK && !inhibit_n && busy) |=> (st == ST_DEFER));

    // R9
    word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_oe |-> (word_q[ANG_W-1:0] == hold_q && !byte_oe));

    // R10
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi_n && en_lo_n) |-> (!byte_oe && !word_oe));
endmodule

bind angle_latch_bus angle_latch_bus_chk #(
    .ANG_W(ANG_W), .WORD_W(WORD_W), .GAP_CYC(GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .inhibit_n (inhibit_n),
    .en_hi_n   (en_hi_n),
    .en_lo_n   (en_lo_n),
    .mid_ok    (mid_ok),
    .st        (st),
    .hold_q    (hold_q),
    .byte_oe   (byte_oe),
    .word_oe   (word_oe),
    .word_q    (word_q)
);

// File: tb/angle_latch_bus_test.sv
`timescale 1ns/1ps
module angle_latch_bus_test;
    localparam int BUSY = 47;
    localparam int MIDC = BUSY / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] angle_in = '0;
    logic        busy = 1'b0;
    logic        inhibit_n = 1'b1;
    logic        en_hi_n = 1'b1;
    logic        en_lo_n = 1'b1;
    logic [7:0]  byte_q;
    logic        byte_oe;
    logic [15:0] word_q;
    logic        word_oe;

    int checks = 0;
    int fails  = 0;

    angle_latch_bus uut (
        .clk(clk), .rst_n(rst_n), .angle_in(angle_in), .busy(busy),
        .inhibit_n(inhibit_n), .en_hi_n(en_hi_n), .en_lo_n(en_lo_n),
        .byte_q(byte_q), .byte_oe(byte_oe), .word_q(word_q), .word_oe(word_oe)
    );

    always #4 clk = ~clk;

    localparam int NV = 8;
    localparam logic [13:0] V_ANG [NV] = '{14'h3A5C, 14'h0001, 14'h3FFF, 14'h2040,
                                           14'h15AA, 14'h003F, 14'h3FC0, 14'h0C35};
    localparam logic [1:0]  V_EN  [NV] = '{2'b01, 2'b10, 2'b00, 2'b11,
                                           2'b01, 2'b10, 2'b00, 2'b01};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset
        en_hi_n = 1'b0; en_lo_n = 1'b0;
        tick(3);
        check("R1 oe during reset", {14'd0, byte_oe, word_oe}, 16'd0);
        check("R1 word during reset", word_q, 16'd0);
        rst_n = 1'b1;
        #1;
        check("R1 held angle after reset", word_q, 16'd0);
        en_hi_n = 1'b1; en_lo_n = 1'b1;

        // Table walk: R2 tracking and R7-R10 lane decode
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  eb;
            logic [15:0] ew;
            logic        ebo, ewo;
            @(negedge clk);
            angle_in = V_ANG[i];
            en_hi_n = 1'b1; en_lo_n = 1'b1;
            @(negedge clk);
            {en_hi_n, en_lo_n} = V_EN[i];
            #1;
            ebo = (V_EN[i] == 2'b01) || (V_EN[i] == 2'b10);
            ewo = (V_EN[i] == 2'b00);
            eb  = (V_EN[i] == 2'b01) ? V_ANG[i][13:6] :
                  (V_EN[i] == 2'b10) ? {2'b00, V_ANG[i][5:0]} : 8'd0;
            ew  = ewo ? {2'b00, V_ANG[i]} : 16'd0;
            check("R2 R7 R8 R9 R10 byte lane", {8'd0, byte_q}, {8'd0, eb});
            check("R7 R8 R9 R10 oe", {14'd0, byte_oe, word_oe}, {14'd0, ebo, ewo});
            check("R2 R9 word lane", word_q, ew);
        end

        en_hi_n = 1'b0; en_lo_n = 1'b0;

        // R4 immediate freeze
        @(negedge clk); angle_in = 14'h1111;
        @(negedge clk); inhibit_n = 1'b0; angle_in = 14'h2222;
        tick(4);
        check("R4 frozen, same-edge angle ignored", word_q, 16'h1111);
        // R6 release from HOLD: first edge no load, second edge loads
        inhibit_n = 1'b1;
        @(negedge clk);
        check("R6 first edge after release", word_q, 16'h1111);
        @(negedge clk);
        check("R6 second edge after release", word_q, 16'h2222);

        // R3 first half of busy ignored, then sampled
        tick(25);
        busy = 1'b1; angle_in = 14'h0A0A;
        tick(MIDC);
        check("R3 first half ignored", word_q, 16'h2222);
        @(negedge clk);
        check("R3 sampled after midpoint", word_q, 16'h0A0A);
        angle_in = 14'h0B0B;
        tick(BUSY - MIDC - 1);
        busy = 1'b0;
        @(negedge clk);
        check("R3 late busy sampled", word_q, 16'h0B0B);

        // R5 deferred inhibit
        tick(25);
        busy = 1'b1; angle_in = 14'h0C0C;
        tick(2);
        inhibit_n = 1'b0;
        tick(MIDC);
        check("R5 deferred still tracking", word_q, 16'h0C0C);
        angle_in = 14'h0D0D;
        tick(BUSY - MIDC - 2);
        busy = 1'b0;
        @(negedge clk);
        check("R5 capture after busy ends", word_q, 16'h0D0D);
        angle_in = 14'h0E0E;
        tick(5);
        check("R5 frozen after capture", word_q, 16'h0D0D);

        // R6 cancel deferred inhibit
        inhibit_n = 1'b1;
        tick(25);
        busy = 1'b1; angle_in = 14'h1234;
        tick(2);
        inhibit_n = 1'b0;
        tick(3);
        inhibit_n = 1'b1;
        tick(BUSY - 5);
        busy = 1'b0;
        angle_in = 14'h2345;
        @(negedge clk);
        angle_in = 14'h3456;
        @(negedge clk);
        check("R6 cancelled defer tracks", word_q, 16'h3456);

        // R1 reset clears a frozen state
        inhibit_n = 1'b0;
        tick(2);
        rst_n = 1'b0;
        tick(2);
        check("R1 lanes off in reset", {14'd0, byte_oe, word_oe}, 16'd0);
        inhibit_n = 1'b1; angle_in = 14'h0777;
        rst_n = 1'b1;
        #1;
        check("R1 cleared hold", word_q, 16'd0);
        @(negedge clk);
        check("R1 R2 tracking after reset", word_q, 16'h0777);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule